// File: doc/BRIEF.md
# Masked Multi-Input Signature Compactor

This block folds the scan-out streams of several groups of parallel scan chains into one signature per test pattern. Every group has its own signature register. It is a shift register with linear feedback that absorbs one bit from each chain of the group on every shift cycle. Ahead of it sits a mask register for that group. A mask bit set to 1 forces its chain's contribution to 0, so an unknown value cannot corrupt the signature. The mask registers are loaded serially between shift cycles. This lets the tester blank any chain on any cycle.

When the pattern ends, the group signatures are combined by XOR into one word. That word is then shifted out over the same pads that carry scan-in data during shifting, a few bits per cycle, and a done pulse follows the last beat. Nothing is driven on the pads while the chains are shifting.

A small controller sequences the block through four states. IDLE waits for `start`. SHIFT compacts chain data on each `shift_en`. UNLOAD drives the signature onto the pads. DONE raises `done` for one cycle. The transitions are: IDLE to SHIFT on `start`, SHIFT to SHIFT on `start` (restart), SHIFT to UNLOAD on `pat_end`, UNLOAD to DONE after the last beat, and DONE to IDLE unconditionally.

Top module: `sigcomp_top`

## Requirements
- R1: After reset the block is in IDLE with `pad_oe` = 0 and `done` = 0, every mask bit is 0 and every signature register holds zero.
- R2: `start` in IDLE or SHIFT clears every group signature to zero and puts the block in SHIFT. A `start` during SHIFT restarts the pattern and discards the data compacted so far.
- R3: On each SHIFT cycle with `shift_en` = 1 and neither `start` nor `pat_end`, each group signature S becomes (S<<1) XOR (S[W-1] ? P : 0) XOR D. P is the low W bits of the feedback polynomial (0x100B for x^16+x^12+x^3+x+1). D is the group's masked chain bits, with chain c of the group at bit c and zero above.
- R4: A mask bit of 1 forces the matching chain input to 0. Global chain j = g*N + c of `chain_so` is controlled by mask bit j. The masks form one serial register: each cycle with `mask_ld` = 1 shifts `mask_sdi` in at the top (bit G*N-1) and moves every bit down one place. After G*N loads, the first bit sent sits at bit 0.
- R5: Mask bits hold their value on every cycle without `mask_ld`, so one loaded mask applies to all later shift cycles until it is reloaded. A load that coincides with a shift is seen from the next shift on.
- R6: The signature read out is the XOR of all group signatures as they stand in the cycle `pat_end` is accepted in SHIFT. A `shift_en` in that same cycle is not compacted.
- R7: Readout lasts W/PINS cycles in UNLOAD with `pad_oe` = 1. In the k-th cycle, `pad_out` carries signature bits [k*PINS +: PINS]. `pad_oe` is 0 in every other state.
- R8: `chain_si` equals `pad_in` whenever `pad_oe` is 0 and is forced to 0 while `pad_oe` is 1.
- R9: `done` is 1 for exactly the one cycle after the last readout beat (state DONE), after which the block returns to IDLE.
- R10: `shift_en` and `start` have no effect during UNLOAD and DONE: the readout continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Pattern start, clears signatures |
| pat_end | input | 1 | Pattern end, begins readout |
| shift_en | input | 1 | Compact one cycle of chain data |
| chain_so | input | GROUPS*CHAINS | Scan-out bits of all chains |
| mask_ld | input | 1 | Shift the serial mask register |
| mask_sdi | input | 1 | Serial mask data |
| pad_in | input | PINS | Shared pad input (scan-in data) |
| pad_out | output | PINS | Shared pad output (signature beats) |
| pad_oe | output | 1 | Pad output enable during readout |
| chain_si | output | PINS | Scan-in data routed to the chains |
| done | output | 1 | One-cycle end-of-readout pulse |

## Verification
On every cycle the assertions check the following: a clear leaves the signature at zero, a signature changes only on a clear or an update, and a mask changes only when loaded. They also check that DONE always falls back to IDLE, that the last beat is followed by `done`, and that `done` is preceded by a driven pad. Only the bench scenarios can show that the signature value is correct. That covers the feedback arithmetic, the mask bit-to-chain mapping and load order, the XOR across groups, the beat order on the pads, and that stray `shift_en`/`start` during readout leave the result intact.

// File: rtl/sigcomp_pkg.sv
package sigcomp_pkg;

    typedef enum logic [1:0] {
        S_IDLE   = 2'd0,
        S_SHIFT  = 2'd1,
        S_UNLOAD = 2'd2,
        S_DONE   = 2'd3
    } sc_state_e;

    // One step of an internal-feedback signature register
    function automatic logic [63:0] sig_step(input logic [63:0] s,
                                             input logic [63:0] d,
                                             input logic [63:0] poly,
                                             input int          w);
        logic [63:0] msk;
        logic [63:0] nx;
        msk = (w >= 64) ? {64{1'b1}} : ((64'd1 << w) - 64'd1);
        nx  = (s << 1) ^ d;
        if (s[w-1]) nx = nx ^ poly;
        return nx & msk;
    endfunction

endpackage

// File: rtl/sigcomp_mask.sv
module sigcomp_mask #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ld,
    input  logic         sdi,
    output logic         sdo,
    output logic [N-1:0] mask
);
    logic [N-1:0] mreg;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  mreg <= '0;
        else if (ld) mreg <= {sdi, mreg[N-1:1]};
    end

    assign mask = mreg;
    assign sdo  = mreg[0];

    // R5: mask holds without a load
    a_r5_mask_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !ld |=> $stable(mreg));
endmodule

// File: rtl/sigcomp_misr.sv
module sigcomp_misr
    import sigcomp_pkg::*;
#(
    parameter int          N    = 4,
    parameter int          W    = 16,
    parameter logic [63:0] POLY = 64'h100B
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         upd,
    input  logic [N-1:0] data,
    input  logic [N-1:0] mask,
    output logic [W-1:0] sig
);
    logic [N-1:0]  gated;
    logic [63:0]   din;
    logic [63:0]   nxt;

    always_comb begin
        gated = data & ~mask;
        din   = '0;
        din[N-1:0] = gated;
        nxt   = sig_step({{(64-W){1'b0}}, sig}, din, POLY, W);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    sig <= '0;
        else if (clr)  sig <= '0;
        else if (upd)  sig <= nxt[W-1:0];
    end

    // R2: a clear leaves the signature at zero
    a_r2_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (sig == '0));
    // R10: no clear and no update means no change
    a_r10_sig_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !upd) |=> $stable(sig));
endmodule

// File: rtl/sigcomp_ctrl.sv
module sigcomp_ctrl
    import sigcomp_pkg::*;
#(
    parameter int W    = 16,
    parameter int PINS = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic            pat_end,
    input  logic            shift_en,
    input  logic [W-1:0]    sig_in,
    output logic            clr,
    output logic            upd,
    output logic            pad_oe,
    output logic            done,
    output logic [PINS-1:0] beat
);
    localparam int BEATS  = W / PINS;
    localparam int BEAT_W = (BEATS > 1) ? $clog2(BEATS) : 1;
    localparam logic [BEAT_W-1:0] LAST = BEAT_W'(BEATS - 1);

    sc_state_e       state, state_nx;
    logic [BEAT_W-1:0] cnt;
    logic [W-1:0]      ureg;

    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:   if (start) state_nx = S_SHIFT;
            S_SHIFT:  if (!start && pat_end) state_nx = S_UNLOAD;
            S_UNLOAD: if (cnt == LAST) state_nx = S_DONE;
            S_DONE:   state_nx = S_IDLE;
            default:  state_nx = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt  <= '0;
            ureg <= '0;
        end else if (state == S_SHIFT && !start && pat_end) begin
            cnt  <= '0;
            ureg <= sig_in;
        end else if (state == S_UNLOAD) begin
            cnt  <= cnt + 1'b1;
            ureg <= ureg >> PINS;
        end
    end

    always_comb begin
        clr    = 1'b0;
        upd    = 1'b0;
        pad_oe = 1'b0;
        done   = 1'b0;
        beat   = '0;
        unique case (state)
            S_IDLE:   clr = start;
            S_SHIFT: begin
                clr = start;
                upd = shift_en && !start && !pat_end;
            end
            S_UNLOAD: begin
                pad_oe = 1'b1;
                beat   = ureg[PINS-1:0];
            end
            S_DONE:   done = 1'b1;
            default:  ;
        endcase
    end

    // R9: DONE lasts one cycle
    a_r9_done_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_DONE) |=> (state == S_IDLE));
    // R7/R9: last beat is followed by done
    a_r7_last_beat_done: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_UNLOAD && cnt == LAST) |=> done);
endmodule

// File: rtl/sigcomp_top.sv
module sigcomp_top
    import sigcomp_pkg::*;
#(
    parameter int          GROUPS = 2,
    parameter int          CHAINS = 4,
    parameter int          W      = 16,
    parameter int          PINS   = 4,
    parameter logic [63:0] POLY   = 64'h100B
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    input  logic                     pat_end,
    input  logic                     shift_en,
    input  logic [GROUPS*CHAINS-1:0] chain_so,
    input  logic                     mask_ld,
    input  logic                     mask_sdi,
    input  logic [PINS-1:0]          pad_in,
    output logic [PINS-1:0]          pad_out,
    output logic                     pad_oe,
    output logic [PINS-1:0]          chain_si,
    output logic                     done
);
    logic              clr, upd;
    logic [W-1:0]      gsig [GROUPS];
    logic [GROUPS:0]   mchain;
    logic [W-1:0]      combined;

    assign mchain[GROUPS] = mask_sdi;

    for (genvar g = 0; g < GROUPS; g++) begin : g_grp
        logic [CHAINS-1:0] gmask;

        sigcomp_mask #(.N(CHAINS)) u_mask (
            .clk  (clk),
            .rst_n(rst_n),
            .ld   (mask_ld),
            .sdi  (mchain[g+1]),
            .sdo  (mchain[g]),
            .mask (gmask)
        );

        sigcomp_misr #(.N(CHAINS), .W(W), .POLY(POLY)) u_misr (
            .clk  (clk),
            .rst_n(rst_n),
            .clr  (clr),
            .upd  (upd),
            .data (chain_so[g*CHAINS +: CHAINS]),
            .mask (gmask),
            .sig  (gsig[g])
        );
    end

    always_comb begin
        combined = '0;
        for (int g = 0; g < GROUPS; g++) combined = combined ^ gsig[g];
    end

    sigcomp_ctrl #(.W(W), .PINS(PINS)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .pat_end (pat_end),
        .shift_en(shift_en),
        .sig_in  (combined),
        .clr     (clr),
        .upd     (upd),
        .pad_oe  (pad_oe),
        .done    (done),
        .beat    (pad_out)
    );

    assign chain_si = pad_oe ? '0 : pad_in;

    // R9: done is always preceded by a driven pad
    a_r9_done_after_oe: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(pad_oe));
endmodule

// File: tb/sim_sigcomp_top.sv
module sim_sigcomp_top;
    localparam int G = 2, N = 4, W = 16, P = 4, T = G*N, BEATS = W/P;
    localparam logic [15:0] POLY = 16'h100B;

    logic clk = 0, rst_n = 0;
    logic start = 0, pat_end = 0, shift_en = 0, mask_ld = 0, mask_sdi = 0;
    logic [T-1:0] chain_so = '0;
    logic [P-1:0] pad_in = '0;
    logic [P-1:0] pad_out, chain_si;
    logic pad_oe, done;

    int nchk = 0, nerr = 0;
    logic [15:0] msig [G];
    logic [T-1:0] mmask;

    always #10 clk = ~clk;

    sigcomp_top #(.GROUPS(G), .CHAINS(N), .W(W), .PINS(P), .POLY(64'h100B)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .pat_end(pat_end),
        .shift_en(shift_en), .chain_so(chain_so), .mask_ld(mask_ld),
        .mask_sdi(mask_sdi), .pad_in(pad_in), .pad_out(pad_out),
        .pad_oe(pad_oe), .chain_si(chain_si), .done(done));

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] step(logic [15:0] s, logic [N-1:0] d);
        logic [15:0] n;
        n = {s[14:0], 1'b0} ^ {12'd0, d};
        if (s[15]) n = n ^ POLY;
        return n;
    endfunction

    task automatic do_start();
        start = 1; @(negedge clk); start = 0;
        for (int g = 0; g < G; g++) msig[g] = '0;
    endtask

    task automatic compact(logic [T-1:0] v);
        shift_en = 1; chain_so = v; @(negedge clk); shift_en = 0;
        for (int g = 0; g < G; g++)
            msig[g] = step(msig[g], v[g*N +: N] & ~mmask[g*N +: N]);
    endtask

    task automatic load_mask(logic [T-1:0] m);
        for (int j = 0; j < T; j++) begin
            mask_ld = 1; mask_sdi = m[j]; @(negedge clk);
        end
        mask_ld = 0; mmask = m;
    endtask

    // readout; noise=1 drives shift_en/start during readout (R10)
    task automatic readout(string tag, bit noise);
        logic [15:0] exp, got;
        exp = '0;
        for (int g = 0; g < G; g++) exp ^= msig[g];
        pat_end = 1; @(negedge clk); pat_end = 0;
        got = '0;
        pad_in = 4'hA;
        for (int k = 0; k < BEATS; k++) begin
            chk({tag, " R7 oe"}, pad_oe, 1);
            chk({tag, " R8 si zero"}, chain_si, 0);
            got[k*P +: P] = pad_out;
            if (noise) begin start = 1; shift_en = 1; chain_so = '1; end
            @(negedge clk);
            start = 0; shift_en = 0;
        end
        chk({tag, " R6 signature"}, got, exp);
        chk({tag, " R9 done"}, done, 1);
        chk({tag, " R7 oe off"}, pad_oe, 0);
        chk({tag, " R8 si pass"}, chain_si, 4'hA);
        @(negedge clk);
        chk({tag, " R9 done drop"}, done, 0);
        pad_in = '0;
    endtask

    task automatic t_reset();
        chk("R1 oe", pad_oe, 0);
        chk("R1 done", done, 0);
        pad_in = 4'h5; #1;
        chk("R8 passthrough idle", chain_si, 4'h5);
        pad_in = '0;
        do_start();
        readout("R1 zero sig", 0);
    endtask

    task automatic t_basic();
        logic [T-1:0] pats [6] = '{8'h81, 8'hFF, 8'h3C, 8'h00, 8'hA5, 8'h1E};
        do_start();
        for (int i = 0; i < 6; i++) compact(pats[i]);
        for (int i = 0; i < 20; i++) compact(8'(i * 37 + 11));
        readout("R3 basic", 0);
    endtask

    task automatic t_feedback();
        do_start();
        compact(8'h08);
        for (int i = 0; i < 15; i++) compact(8'h00); // bit reaches MSB, then feeds back
        compact(8'h00);
        compact(8'h00);
        readout("R3 feedback", 0);
    endtask

    task automatic t_mask();
        do_start();
        load_mask(8'b1010_0110);
        compact(8'hFF); compact(8'h5A);
        load_mask(8'b0000_0001);        // R5: per-cycle change
        compact(8'hFF);
        compact(8'h01);
        load_mask(8'hFF);
        compact(8'hFF); compact(8'hC3);  // fully masked: R4
        readout("R4 mask", 0);
        load_mask(8'h00);
    endtask

    task automatic t_mask_all();
        do_start();
        load_mask(8'hFF);
        for (int i = 0; i < 5; i++) compact(8'(i * 53 + 7));
        readout("R4 all masked zero", 0);
        load_mask(8'h00);
    endtask

    task automatic t_restart();
        do_start();
        compact(8'h77); compact(8'h12);
        do_start();                      // R2 restart discards
        compact(8'h40);
        readout("R2 restart", 0);
    endtask

    task automatic t_end_with_shift();
        logic [15:0] exp;
        do_start();
        compact(8'h96);
        shift_en = 1; chain_so = 8'hFF;  // R6: same-cycle shift not compacted
        readout("R6 end+shift", 0);
        shift_en = 0;
    endtask

    task automatic t_noise();
        do_start();
        compact(8'h3A); compact(8'hC5);
        readout("R10 noise during readout", 1);
    endtask

    initial begin
        #(20 * 200000);
        nerr++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nerr);
        $finish;
    end

    initial begin
        mmask = '0;
        for (int g = 0; g < G; g++) msig[g] = '0;
        @(negedge clk); @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_feedback();
        t_mask();
        t_mask_all();
        t_restart();
        t_end_with_shift();
        t_noise();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nerr);
        $finish;
    end
endmodule